// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

This block connects a processor's load/store request port to a memory bus that is four byte lanes wide. A request gives a byte address, a size code (one, two or four bytes), a direction flag and, for stores, right-justified data. The block turns it into bus cycles. Each cycle carries a word address and active-low per-lane enables. Write data is rotated onto the proper lanes. An access whose bytes stay inside one aligned 4-byte word takes one bus cycle. An access that runs past the end of its word is split into two cycles: the first covers the word holding the start address, and the second covers the next word up.

For loads, the bytes returned in one or two cycles are put together into a right-justified, zero-extended result. The requester raises a one-cycle valid strobe while the block is idle. It then watches `busy` and waits for the single `done` pulse that marks the end of the whole access. The memory side ends each cycle by raising `bus_ready`. The cycle's address and enables hold steady until then.

Top module: `mem_access_splitter`

## Requirements
- R1: After reset, `busy`, `done`, `bus_cyc` and `bus_wr` are 0 and `bus_be_n` is 4'b1111.
- R2: A request is taken only when `req_valid` is high at a clock edge while the block is idle. A `req_valid` raised while an access is in progress has no effect on the bus cycles or the result of that access.
- R3: `bus_addr` is the request address with bits [1:0] cleared. The second cycle of a split access uses that address plus 4.
- R4: `bus_be_n[i]` is low exactly when byte lane i is transferred in the current cycle, and it is 4'b1111 whenever `bus_cyc` is low. The lanes of the whole access start at lane `addr[1:0]` and cover N consecutive byte positions. The size code gives N: 2'b00 is 1, 2'b01 is 2, 2'b10 is 4.
- R5: An access with `addr[1:0]` + N <= 4 uses exactly one bus cycle. Otherwise it uses two: the first enables lanes `addr[1:0]` to 3, and the second enables lanes 0 upward for the remaining bytes (for example, 4 bytes at address 5 give lanes 1 to 3, then lane 0 alone).
- R6: A bus cycle stays in progress, with `bus_addr` and `bus_be_n` unchanged, until `bus_ready` is sampled high.
- R7: `done` is high for exactly one clock, in the cycle after the clock edge that samples `bus_ready` for the final bus cycle. `busy` is high from the cycle after acceptance up to that point and is low while `done` is high.
- R8: During a store cycle `bus_wr` is 1, and lane i of `bus_wdata` carries byte ((i - `addr[1:0]`) mod 4) of `req_wdata` when that lane is enabled and 0 otherwise. On loads and between cycles, `bus_wr` is 0 and `bus_wdata` is 0.
- R9: When a load completes, byte k of `rdata` (for k < N) is the memory byte at request address + k, taken from the first cycle's lanes and then from the second cycle's. Bytes N and above are 0.
- R10: The size code 2'b11 behaves exactly like 2'b10 (four bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code: 00 one byte, 01 two, 1x four |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Store data, right-justified |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock pulse at the end of an access |
| rdata | output | 32 | Load result, right-justified and zero-extended |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be_n | output | 4 | Per-lane byte enables, active low |
| bus_wr | output | 1 | Current cycle is a store |
| bus_wdata | output | 32 | Lane-placed store data |
| bus_rdata | input | 32 | Data returned by memory, sampled with bus_ready |
| bus_ready | input | 1 | Ends the current bus cycle |

## Verification
If the block lost track of which half of a split it is running, the effect would show on the bus at once. The second cycle would repeat the first word address or the first lane pattern, or it would be left out, so the fault shows in the very next cycle after `bus_ready`. Wrong captured first-cycle data or a wrong byte offset stays hidden on the bus. It shows only in `rdata` in the cycle where `done` pulses, which is why every load result is compared byte by byte with a memory model. A phase register stuck busy would show as a missing `done` and a run that never finishes.

// File: rtl/splt_pkg.sv
package splt_pkg;
    parameter int LANES  = 4;
    parameter int BYTE_W = 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } phase_e;

    // Size code to byte count; codes 2 and 3 both mean a full word.
    function automatic logic [LANE_W:0] size_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return (LANE_W+1)'(1);
            2'b01:   return (LANE_W+1)'(2);
            default: return (LANE_W+1)'(LANES);
        endcase
    endfunction
endpackage

// File: rtl/splt_plan.sv
module splt_plan
    import splt_pkg::*;
(
    input  logic [LANE_W-1:0] off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_W:0]   nbytes,
    output logic [LANES-1:0]  en_lo,
    output logic [LANES-1:0]  en_hi,
    output logic              split,
    output logic [DATA_W-1:0] wdata_rot
);
    logic [2*LANES-1:0] span;

    assign nbytes = size_bytes(size);

    // Byte positions covered across two adjacent words.
    always_comb begin
        for (int i = 0; i < 2*LANES; i++) begin
            span[i] = (i >= int'(off)) && (i < int'(off) + int'(nbytes));
        end
    end

    assign en_lo = span[LANES-1:0];
    assign en_hi = span[2*LANES-1:LANES];
    assign split = |en_hi;

    // Rotate store data left by the byte offset.
    for (genvar j = 0; j < LANES; j++) begin : g_rot
        logic [LANE_W-1:0] src;
        assign src = LANE_W'(j) - off;
        assign wdata_rot[j*BYTE_W +: BYTE_W] = wdata[src*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/splt_gather.sv
module splt_gather
    import splt_pkg::*;
(
    input  logic [DATA_W-1:0] first_word,
    input  logic [DATA_W-1:0] cur_word,
    input  logic              second,
    input  logic [LANE_W-1:0] off,
    input  logic [LANE_W:0]   nbytes,
    output logic [DATA_W-1:0] result
);
    logic [2*DATA_W-1:0] both;
    logic [2*DATA_W-1:0] shifted;

    assign both    = second ? {cur_word, first_word} : {{DATA_W{1'b0}}, cur_word};
    assign shifted = both >> (int'(off) * BYTE_W);

    for (genvar k = 0; k < LANES; k++) begin : g_zext
        assign result[k*BYTE_W +: BYTE_W] =
            (k < int'(nbytes)) ? shifted[k*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/mem_access_splitter.sv
module mem_access_splitter
    import splt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] waddr;
        logic [LANES-1:0]  en_lo;
        logic [LANES-1:0]  en_hi;
        logic              split;
        logic              wr;
        logic [LANE_W-1:0] off;
        logic [LANE_W:0]   nb;
        logic [DATA_W-1:0] wrot;
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } regs_t;

    regs_t s_d, s_q;

    logic [LANE_W:0]   p_nb;
    logic [LANES-1:0]  p_en_lo, p_en_hi;
    logic              p_split;
    logic [DATA_W-1:0] p_wrot;
    logic [DATA_W-1:0] merged;
    logic [LANES-1:0]  en_now;

    splt_plan u_plan (
        .off       (req_addr[LANE_W-1:0]),
        .size      (req_size),
        .wdata     (req_wdata),
        .nbytes    (p_nb),
        .en_lo     (p_en_lo),
        .en_hi     (p_en_hi),
        .split     (p_split),
        .wdata_rot (p_wrot)
    );

    splt_gather u_gather (
        .first_word (s_q.first),
        .cur_word   (bus_rdata),
        .second     (s_q.phase == ST_SECOND),
        .off        (s_q.off),
        .nbytes     (s_q.nb),
        .result     (merged)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.phase = ST_FIRST;
                    s_d.waddr = {req_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    s_d.en_lo = p_en_lo;
                    s_d.en_hi = p_en_hi;
                    s_d.split = p_split;
                    s_d.wr    = req_write;
                    s_d.off   = req_addr[LANE_W-1:0];
                    s_d.nb    = p_nb;
                    s_d.wrot  = p_wrot;
                end
            end
            ST_FIRST: begin
                if (bus_ready) begin
                    s_d.first = bus_rdata;
                    if (s_q.split) begin
                        s_d.phase = ST_SECOND;
                        s_d.waddr = s_q.waddr + ADDR_W'(LANES);
                    end else begin
                        s_d.phase = ST_IDLE;
                        s_d.done  = 1'b1;
                        if (!s_q.wr) s_d.rdata = merged;
                    end
                end
            end
            ST_SECOND: begin
                if (bus_ready) begin
                    s_d.phase = ST_IDLE;
                    s_d.done  = 1'b1;
                    if (!s_q.wr) s_d.rdata = merged;
                end
            end
            default: s_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_cyc  = (s_q.phase != ST_IDLE);
    assign en_now   = (s_q.phase == ST_SECOND) ? s_q.en_hi : s_q.en_lo;
    assign bus_be_n = bus_cyc ? ~en_now : '1;
    assign bus_addr = s_q.waddr;
    assign bus_wr   = bus_cyc && s_q.wr;
    assign busy     = bus_cyc;
    assign done     = s_q.done;
    assign rdata    = s_q.rdata;

    for (genvar j = 0; j < LANES; j++) begin : g_wlane
        assign bus_wdata[j*BYTE_W +: BYTE_W] =
            (bus_wr && en_now[j]) ? s_q.wrot[j*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/splt_chk.sv
module splt_chk
    import splt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_cyc,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]  bus_be_n
);
    AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_addr[LANE_W-1:0] == '0); // R3
    AST_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ready) |=> (!bus_cyc || bus_addr == $past(bus_addr) + ADDR_W'(LANES))); // R3
    AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> $countones(~bus_be_n) >= 1); // R4
    AST_SECOND_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_ready) |=> (!bus_cyc || !bus_be_n[0])); // R5
    AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ready) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be_n))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7
endmodule

bind mem_access_splitter splt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_cyc   (bus_cyc),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_be_n  (bus_be_n)
);

// File: tb/sim_mem_access_splitter.sv
module sim_mem_access_splitter;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          busy, done, bus_cyc, bus_wr;
    logic [31:0]   rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be_n;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mem_access_splitter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_cyc(bus_cyc),
        .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] wa);
        logic [31:0] w;
        for (int l = 0; l < 4; l++) w[l*8 +: 8] = mem_byte(wa + 32'(l));
        return w;
    endfunction

    function automatic int nbytes_of(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    function automatic logic [7:0] span_of(input logic [31:0] a, input logic [1:0] s);
        logic [7:0] sp;
        for (int i = 0; i < 8; i++) sp[i] = (i >= int'(a[1:0])) && (i < int'(a[1:0]) + nbytes_of(s));
        return sp;
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [1:0] s);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes_of(s); k++) r[k*8 +: 8] = mem_byte(a + 32'(k));
        return r;
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [31:0] a, input logic [31:0] d,
                                              input logic [3:0] en, input bit w);
        logic [31:0] rot, r;
        int sh = int'(a[1:0]) * 8;
        rot = (d << sh) | (d >> (32 - sh));
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = (w && en[l]) ? rot[l*8 +: 8] : 8'h00;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic [31:0] a, input logic [1:0] s, input bit w, input logic [31:0] wd);
        logic [7:0]  sp = span_of(a, s);
        int          ncyc = (sp[7:4] != 0) ? 2 : 1;
        logic [31:0] er = exp_read(a, s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; req_write = w; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        for (int c = 0; c < ncyc; c++) begin
            logic [3:0]  en = (c == 0) ? sp[3:0] : sp[7:4];
            logic [31:0] ea = {a[31:2], 2'b00} + 32'(4 * c);
            int waits = int'($urandom % 3);
            for (int k = 0; k < waits; k++) begin
                // R2: a request while busy must be ignored
                req_valid = 1'b1; req_addr = ~a; req_size = ~s; req_write = ~w; req_wdata = ~wd;
                chk(bus_cyc && bus_addr == ea, "R6 address held", bus_addr, ea);
                chk(bus_be_n == ~en, "R6 enables held", 32'(bus_be_n), 32'(~en));
                @(negedge clk);
            end
            req_valid = 1'b0;
            chk(bus_cyc == 1'b1, "R5 cycle in progress", 32'(bus_cyc), 32'd1);
            chk(bus_addr == ea, "R3 word address", bus_addr, ea);
            chk(bus_be_n == ~en, "R4 R5 R10 enables", 32'(bus_be_n), 32'(~en));
            chk(bus_wr == w, "R8 write flag", 32'(bus_wr), 32'(w));
            chk(bus_wdata == exp_wdata(a, wd, en, w), "R8 lane data", bus_wdata, exp_wdata(a, wd, en, w));
            bus_ready = 1'b1;
            bus_rdata = mem_word(ea);
            @(negedge clk);
            bus_ready = 1'b0;
            bus_rdata = $urandom;
        end
        chk(done == 1'b1, "R7 done after final ready", 32'(done), 32'd1);
        chk(busy == 1'b0, "R7 busy low with done", 32'(busy), 32'd0);
        if (!w) chk(rdata == er, "R9 load result", rdata, er);
        @(negedge clk);
        chk(done == 1'b0, "R7 single done pulse", 32'(done), 32'd0);
        chk(bus_cyc == 1'b0 && bus_be_n == 4'hF, "R4 idle enables", 32'(bus_be_n), 32'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done", {30'd0, busy, done}, 32'd0);
        chk(bus_cyc == 1'b0 && bus_wr == 1'b0, "R1 bus idle", {30'd0, bus_cyc, bus_wr}, 32'd0);
        chk(bus_be_n == 4'hF, "R1 enables", 32'(bus_be_n), 32'hF);
        rst_n = 1'b1;
        // directed corner cases
        do_access(32'h0000_0005, 2'b10, 1'b0, 32'h0);          // R5 split 3+1
        do_access(32'h0000_0000, 2'b10, 1'b0, 32'h0);          // aligned word
        do_access(32'h0000_0103, 2'b01, 1'b0, 32'h0);          // split half
        do_access(32'h0000_0102, 2'b01, 1'b0, 32'h0);          // aligned half
        do_access(32'h0000_0207, 2'b00, 1'b0, 32'h0);          // byte at lane 3
        do_access(32'h0000_0306, 2'b11, 1'b0, 32'h0);          // R10 code 3 split
        do_access(32'h0000_0401, 2'b10, 1'b1, 32'hA1B2_C3D4);  // split store
        do_access(32'h0000_0503, 2'b01, 1'b1, 32'h0000_5A6B);  // split half store
        do_access(32'hFFFF_FFFE, 2'b10, 1'b0, 32'h0);          // address wrap
        for (int n = 0; n < 400; n++) begin
            do_access($urandom, 2'($urandom), 1'($urandom), $urandom);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule